// File: doc/BRIEF.md
# Biosignal ADC Command Controller

This block sits between a host byte stream and a multichannel biosignal converter that is reached over SPI. The host writes command bytes into a 512-byte buffer. The controller pulls them out, classifies the opcode and then runs one of three sequences. It can stream sample frames, read a run of converter registers back to the host, or write a run of registers from bytes the host supplied. Short one-byte commands for wake, standby and reset pass straight through as a single SPI byte.

The SPI side works at byte level. The controller holds an active-low select for the whole command, pulses a start strobe with the byte to shift, and waits for a done strobe with the byte received. Bytes read back are returned on a one-cycle valid strobe. While a select is low, the controller raises its stall output, so a host that offers a byte is held off until the transaction ends. A register write does not open the select until its full payload is buffered, so the stall can never freeze a half-delivered command.

Top module: `biosig_adc_ctrl`

## Requirements
- R1: During reset the select is high and stall, response valid, error and SPI start are all low.
- R2: The opcodes 0x02, 0x04, 0x06 and 0x11 (outside streaming) each produce exactly one SPI byte equal to the opcode, sent while the select is low. The select returns high afterwards.
- R3: A register read is opcode 0x20 plus a 5-bit start address, followed by a count byte c. It sends the opcode, then c, then c+1 bytes of 0x00. The c+1 bytes received go to the host in order, and the address wraps modulo 32 on the converter side.
- R4: A register write is opcode 0x40 plus a 5-bit address, followed by a count byte c and c+1 data bytes. It sends all c+3 bytes in that order and returns nothing to the host. The select stays high until every data byte has been buffered.
- R5: Whenever the select is low, stall is high.
- R6: Any other opcode (outside streaming) is dropped. The error output pulses for one cycle, and no SPI byte is sent. The next command runs normally.
- R7: Opcode 0x10 followed by an interval byte k sends 0x10 under select and then enters streaming. In streaming, every (k+1)-th falling edge of the data-ready input starts a 27-byte read of 0x00 bytes under one select. All 27 received bytes go to the host.
- R8: In streaming, a buffered 0x11 is sent as one SPI byte and streaming ends. Later data-ready edges start no SPI traffic.
- R9: In streaming, any buffered byte other than 0x11 is dropped with a one-cycle error pulse. Streaming continues on the same interval.
- R10: The host writes one byte per cycle in which in_valid is high and stall is low. A byte held on the input while stall is high is taken once, after stall falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host byte offered |
| in_data | input | 8 | Host command byte |
| stall | output | 1 | Host must hold its byte (select low or buffer full) |
| rsp_valid | output | 1 | One-cycle strobe for a returned byte |
| rsp_data | output | 8 | Returned register or sample byte |
| err | output | 1 | One-cycle pulse on a dropped opcode |
| spi_cs_n | output | 1 | Active-low converter select |
| spi_start | output | 1 | One-cycle request to shift spi_tx |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte shifted in |
| drdy_n | input | 1 | Converter data-ready, falling edge marks a new sample |

## Verification
The assertions rely on three conditions in the environment. The SPI engine answers each start strobe with exactly one done strobe, never in the cycle of the strobe itself. The host only offers bytes through the stall handshake. Data-ready edges arrive far enough apart that a frame finishes before the next request. The bench's converter model answers three cycles after each start. Its driver waits for stall to be low before each byte, except in the deliberate hold test. Data-ready pulses are spaced by waiting until every expected SPI byte has been seen.

// File: rtl/biosig_cmd_pkg.sv
package biosig_cmd_pkg;

  localparam logic [7:0] OP_WAKE   = 8'h02;
  localparam logic [7:0] OP_STBY   = 8'h04;
  localparam logic [7:0] OP_RESET  = 8'h06;
  localparam logic [7:0] OP_STREAM = 8'h10;
  localparam logic [7:0] OP_STOP   = 8'h11;
  localparam logic [2:0] GRP_RD    = 3'b001;
  localparam logic [2:0] GRP_WR    = 3'b010;

  typedef enum logic [2:0] {
    C_BAD, C_SIMPLE, C_STREAM, C_RREG, C_WREG
  } op_class_e;

  typedef enum logic [1:0] {
    K_CMD, K_RREG, K_WREG, K_FRAME
  } xfer_kind_e;

endpackage

// File: rtl/biosig_cmd_fifo.sv
module biosig_cmd_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_en, rd_en;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr_en = push & ~full;
  assign rd_en = pop & ~empty;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rd_en) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R10: the sequencer only pops bytes that are present
  a_r10_pop_when_filled: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r10_count_in_range: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

endmodule

// File: rtl/biosig_op_decode.sv
module biosig_op_decode
  import biosig_cmd_pkg::*;
(
  input  logic [7:0] op,
  output op_class_e  cls
);
  always_comb begin
    if (op[7:5] == GRP_RD)      cls = C_RREG;
    else if (op[7:5] == GRP_WR) cls = C_WREG;
    else begin
      case (op)
        OP_WAKE, OP_STBY, OP_RESET, OP_STOP: cls = C_SIMPLE;
        OP_STREAM:                           cls = C_STREAM;
        default:                             cls = C_BAD;
      endcase
    end
  end
endmodule

// File: rtl/biosig_frame_pacer.sv
module biosig_frame_pacer #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          drdy_n,
  input  logic [IW-1:0] interval,
  input  logic          ack,
  output logic          pend
);
  logic          drdy_d;
  logic [IW-1:0] cnt;
  logic          fall;

  assign fall = drdy_d & ~drdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_d <= 1'b1;
      cnt    <= '0;
      pend   <= 1'b0;
    end else begin
      drdy_d <= drdy_n;
      if (!en) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        if (ack) pend <= 1'b0;
        if (fall) begin
          if (cnt == interval) begin
            cnt  <= '0;
            pend <= 1'b1;
          end else begin
            cnt <= cnt + IW'(1);
          end
        end
      end
    end
  end

  // R8: outside streaming no frame request survives
  a_r8_no_request_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pend);

endmodule

// File: rtl/biosig_adc_ctrl.sv
module biosig_adc_ctrl
  import biosig_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH  = 512,
  parameter int FRAME_BYTES = 27
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       stall,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       err,
  output logic       spi_cs_n,
  output logic       spi_start,
  output logic [7:0] spi_tx,
  input  logic       spi_done,
  input  logic [7:0] spi_rx,
  input  logic       drdy_n
);
  localparam int CW      = $clog2(FIFO_DEPTH+1);
  localparam int MAX_TOT = (FRAME_BYTES > 258) ? FRAME_BYTES : 258;
  localparam int XW      = $clog2(MAX_TOT+1);

  typedef enum logic [3:0] {
    S_IDLE, S_OP, S_PWAIT, S_PARAM, S_GATHER, S_LOAD, S_FETCH,
    S_WAITD, S_END, S_STREAM, S_SCMD
  } state_e;

  state_e     state;
  op_class_e  dec_cls, cls_q;
  xfer_kind_e kind_q;
  logic [7:0] op_q, prm_q, tx_q, rsp_q, fifo_q, hdr_byte;
  logic [XW-1:0] idx_q, last_q;
  logic [CW-1:0] fifo_cnt;
  logic cs_n_q, start_q, rsp_v_q, err_q, stream_q;
  logic fifo_empty, fifo_full, fifo_pop, fifo_push;
  logic pace_pend, pace_ack, ret_byte;

  assign stall     = ~cs_n_q | fifo_full;
  assign fifo_push = in_valid & ~stall;

  biosig_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
    .clk(clk), .rst(rst), .push(fifo_push), .din(in_data),
    .pop(fifo_pop), .dout(fifo_q), .empty(fifo_empty),
    .full(fifo_full), .count(fifo_cnt)
  );

  biosig_op_decode dec_i (.op(fifo_q), .cls(dec_cls));

  biosig_frame_pacer #(.IW(8)) pacer_i (
    .clk(clk), .rst(rst), .en(stream_q), .drdy_n(drdy_n),
    .interval(prm_q), .ack(pace_ack), .pend(pace_pend)
  );

  always_comb begin
    fifo_pop = 1'b0;
    case (state)
      S_IDLE, S_PWAIT: fifo_pop = ~fifo_empty;
      S_LOAD:          fifo_pop = (kind_q == K_WREG) && (idx_q >= XW'(2));
      S_STREAM:        fifo_pop = ~pace_pend & ~fifo_empty;
      default:         fifo_pop = 1'b0;
    endcase
  end

  assign pace_ack = (state == S_STREAM) && pace_pend;
  assign hdr_byte = (kind_q == K_FRAME) ? 8'h00 :
                    (idx_q == XW'(0))   ? op_q  :
                    (idx_q == XW'(1))   ? prm_q : 8'h00;
  assign ret_byte = (kind_q == K_FRAME) ||
                    ((kind_q == K_RREG) && (idx_q >= XW'(2)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cls_q    <= C_BAD;
      kind_q   <= K_CMD;
      op_q     <= '0;
      prm_q    <= '0;
      tx_q     <= '0;
      rsp_q    <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      cs_n_q   <= 1'b1;
      start_q  <= 1'b0;
      rsp_v_q  <= 1'b0;
      err_q    <= 1'b0;
      stream_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      rsp_v_q <= 1'b0;
      err_q   <= 1'b0;
      case (state)
        S_IDLE: if (!fifo_empty) state <= S_OP;
        S_OP: begin
          op_q  <= fifo_q;
          cls_q <= dec_cls;
          case (dec_cls)
            C_SIMPLE: begin
              kind_q <= K_CMD; last_q <= '0; idx_q <= '0;
              cs_n_q <= 1'b0;  state <= S_LOAD;
            end
            C_STREAM, C_RREG, C_WREG: state <= S_PWAIT;
            default: begin
              err_q <= 1'b1; state <= S_IDLE;
            end
          endcase
        end
        S_PWAIT: if (!fifo_empty) state <= S_PARAM;
        S_PARAM: begin
          prm_q <= fifo_q;
          idx_q <= '0;
          case (cls_q)
            C_STREAM: begin
              kind_q <= K_CMD; last_q <= '0;
              cs_n_q <= 1'b0;  state <= S_LOAD;
            end
            C_RREG: begin
              kind_q <= K_RREG; last_q <= XW'(fifo_q) + XW'(2);
              cs_n_q <= 1'b0;   state <= S_LOAD;
            end
            C_WREG:  state <= S_GATHER;
            default: state <= S_IDLE;
          endcase
        end
        S_GATHER: if (fifo_cnt >= CW'(prm_q) + CW'(1)) begin
          kind_q <= K_WREG; last_q <= XW'(prm_q) + XW'(2);
          cs_n_q <= 1'b0;   state <= S_LOAD;
        end
        S_LOAD: begin
          if ((kind_q == K_WREG) && (idx_q >= XW'(2))) begin
            state <= S_FETCH;
          end else begin
            tx_q <= hdr_byte; start_q <= 1'b1; state <= S_WAITD;
          end
        end
        S_FETCH: begin
          tx_q <= fifo_q; start_q <= 1'b1; state <= S_WAITD;
        end
        S_WAITD: if (spi_done) begin
          if (ret_byte) begin
            rsp_v_q <= 1'b1; rsp_q <= spi_rx;
          end
          if (idx_q == last_q) state <= S_END;
          else begin
            idx_q <= idx_q + XW'(1); state <= S_LOAD;
          end
        end
        S_END: begin
          cs_n_q <= 1'b1;
          if (kind_q == K_CMD && op_q == OP_STREAM) begin
            stream_q <= 1'b1; state <= S_STREAM;
          end else if (kind_q == K_FRAME) begin
            state <= S_STREAM;
          end else begin
            if (kind_q == K_CMD && op_q == OP_STOP) stream_q <= 1'b0;
            state <= S_IDLE;
          end
        end
        S_STREAM: begin
          if (pace_pend) begin
            kind_q <= K_FRAME; last_q <= XW'(FRAME_BYTES-1); idx_q <= '0;
            cs_n_q <= 1'b0;    state <= S_LOAD;
          end else if (!fifo_empty) begin
            state <= S_SCMD;
          end
        end
        S_SCMD: begin
          if (fifo_q == OP_STOP) begin
            op_q   <= fifo_q; kind_q <= K_CMD; last_q <= '0; idx_q <= '0;
            cs_n_q <= 1'b0;   state <= S_LOAD;
          end else begin
            err_q <= 1'b1; state <= S_STREAM;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_start = start_q;
  assign spi_tx    = tx_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;
  assign err       = err_q;

  // R1: quiet outputs while reset is applied
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (spi_cs_n && !rsp_valid && !err && !spi_start));
  // R2: byte strobes only inside a select window
  a_r2_start_under_select: assert property (@(posedge clk) disable iff (rst)
    spi_start |-> !spi_cs_n);
  a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
    spi_start |=> !spi_start);
  // R3: a returned byte always follows a finished exchange
  a_r3_rsp_after_done: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(spi_done));
  // R5: host is held off for the whole select window
  a_r5_stall_during_select: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> stall);
  // R6: dropped opcode gives a lone pulse with no SPI activity
  a_r6_err_single_pulse: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  a_r6_err_no_select: assert property (@(posedge clk) disable iff (rst)
    err |-> spi_cs_n);

endmodule

// File: tb/biosig_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module biosig_adc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic drdy_n = 1'b1;
  logic spi_done = 1'b0;
  logic [7:0] spi_rx = 8'h00;
  logic stall, rsp_valid, err, spi_cs_n, spi_start;
  logic [7:0] rsp_data, spi_tx;

  always #4 clk = ~clk;

  biosig_adc_ctrl dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .stall(stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err(err),
    .spi_cs_n(spi_cs_n), .spi_start(spi_start), .spi_tx(spi_tx),
    .spi_done(spi_done), .spi_rx(spi_rx), .drdy_n(drdy_n)
  );

  int checks = 0, errors = 0, cyc = 0;
  int starts = 0, exp_starts = 0, err_seen = 0, stall_gap = 0;
  int frame_no = 0, exp_frame = 0, pos = 0, dly = 0;
  bit model_stream = 1'b0;
  logic [7:0] cur_op = 8'h00, pend_miso = 8'h00;
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rsp[$];
  logic [7:0] model_regs[32];
  logic [7:0] mirror[32];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and SPI scoreboard
  always @(negedge clk) begin
    logic [7:0] e;
    spi_done = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin spi_done = 1'b1; spi_rx = pend_miso; end
    end
    if (spi_cs_n) pos = 0;
    if (spi_start) begin
      starts++;
      if (spi_cs_n) check(1'b0, "R2 start with select high", 1, 0);
      if (exp_mosi.size() == 0) check(1'b0, "R2 unexpected SPI byte", int'(spi_tx), -1);
      else begin
        e = exp_mosi.pop_front();
        check(spi_tx == e, "R2/R3/R4/R7 SPI byte", int'(spi_tx), int'(e));
      end
      if (pos == 0) begin
        cur_op = spi_tx;
        if (model_stream && spi_tx == 8'h00) frame_no++;
      end
      pend_miso = 8'h00;
      if (model_stream && cur_op == 8'h00) pend_miso = 8'(frame_no * 37 + pos);
      else if (cur_op[7:5] == 3'b001 && pos >= 2)
        pend_miso = model_regs[(int'(cur_op[4:0]) + pos - 2) % 32];
      else if (cur_op[7:5] == 3'b010 && pos >= 2)
        model_regs[(int'(cur_op[4:0]) + pos - 2) % 32] = spi_tx;
      pos++;
      dly = 3;
    end
  end

  // response scoreboard, error and stall monitors
  always @(negedge clk) begin
    logic [7:0] e;
    if (!rst) begin
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) check(1'b0, "R3/R7 unexpected response", int'(rsp_data), -1);
        else begin
          e = exp_rsp.pop_front();
          check(rsp_data == e, "R3/R7 response byte", int'(rsp_data), int'(e));
        end
      end
      if (err) err_seen++;
      if (!spi_cs_n && !stall) stall_gap++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    while (stall) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic want(input logic [7:0] b);
    exp_mosi.push_back(b);
    exp_starts++;
  endtask

  task automatic wait_quiet();
    int n = 0;
    while ((exp_mosi.size() != 0 || !spi_cs_n || dly != 0) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic do_simple(input logic [7:0] op);
    want(op);
    send_byte(op);
  endtask

  task automatic queue_rreg(input int a, input int n);
    want(8'h20 | 8'(a));
    want(8'(n - 1));
    for (int i = 0; i < n; i++) begin
      want(8'h00);
      exp_rsp.push_back(mirror[(a + i) % 32]);
    end
  endtask

  task automatic do_rreg(input int a, input int n);
    queue_rreg(a, n);
    send_byte(8'h20 | 8'(a));
    send_byte(8'(n - 1));
  endtask

  task automatic queue_frame();
    exp_frame++;
    for (int p = 0; p < 27; p++) begin
      want(8'h00);
      exp_rsp.push_back(8'(exp_frame * 37 + p));
    end
  endtask

  task automatic drdy_pulse();
    @(negedge clk);
    drdy_n = 1'b0;
    repeat (2) @(negedge clk);
    drdy_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int s0, e0;
    for (int i = 0; i < 32; i++) begin
      model_regs[i] = 8'(i * 13 + 5);
      mirror[i]     = 8'(i * 13 + 5);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1, "R1 select high in reset", int'(spi_cs_n), 1);
    check(stall == 1'b0 && err == 1'b0, "R1 stall/err low in reset", int'({stall, err}), 0);
    check(rsp_valid == 1'b0 && spi_start == 1'b0, "R1 rsp/start low in reset",
          int'({rsp_valid, spi_start}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 one-byte commands
    do_simple(8'h02); do_simple(8'h04); do_simple(8'h06); do_simple(8'h11);
    wait_quiet();
    check(starts == exp_starts, "R2 simple byte count", starts, exp_starts);
    check(spi_cs_n == 1'b1, "R2 select released", int'(spi_cs_n), 1);

    // R3 register reads, including address wrap
    do_rreg(3, 4);
    do_rreg(30, 3);
    wait_quiet();
    check(exp_rsp.size() == 0, "R3 all read bytes returned", exp_rsp.size(), 0);

    // R4 register write, payload delivered in two parts
    s0 = starts;
    send_byte(8'h45); send_byte(8'h02); send_byte(8'hAA);
    repeat (20) @(negedge clk);
    check(spi_cs_n == 1'b1 && starts == s0, "R4 select waits for full payload", starts, s0);
    want(8'h45); want(8'h02); want(8'hAA); want(8'hBB); want(8'hCC);
    mirror[5] = 8'hAA; mirror[6] = 8'hBB; mirror[7] = 8'hCC;
    send_byte(8'hBB); send_byte(8'hCC);
    wait_quiet();
    check(exp_rsp.size() == 0, "R4 write returns nothing", exp_rsp.size(), 0);
    do_rreg(5, 3);
    wait_quiet();
    check(exp_rsp.size() == 0 && starts == exp_starts, "R4 written values read back",
          starts, exp_starts);

    // R6 unknown opcode
    s0 = starts; e0 = err_seen;
    send_byte(8'hFF);
    repeat (10) @(negedge clk);
    check(err_seen == e0 + 1, "R6 one error pulse", err_seen, e0 + 1);
    check(starts == s0, "R6 no SPI byte for unknown opcode", starts, s0);
    do_simple(8'h02);
    wait_quiet();
    check(starts == s0 + 1, "R6 next command runs", starts, s0 + 1);

    // R10 byte held on the input across a stalled transaction
    queue_rreg(0, 8);
    want(8'h04);
    send_byte(8'h20); send_byte(8'h07);
    while (!stall) @(negedge clk);
    in_valid = 1'b1; in_data = 8'h04;
    while (stall) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_quiet();
    check(starts == exp_starts, "R10 held byte taken once", starts, exp_starts);

    // R7 streaming with interval byte 1: every second edge
    want(8'h10);
    send_byte(8'h10); send_byte(8'h01);
    wait_quiet();
    model_stream = 1'b1;
    s0 = starts;
    drdy_pulse();
    wait_quiet();
    check(starts == s0, "R7 first edge skipped", starts, s0);
    queue_frame();
    drdy_pulse();
    wait_quiet();
    check(starts == s0 + 27, "R7 frame of 27 bytes", starts, s0 + 27);
    drdy_pulse();
    queue_frame();
    drdy_pulse();
    wait_quiet();
    check(exp_rsp.size() == 0, "R7 two frames returned", exp_rsp.size(), 0);

    // R9 stray byte while streaming
    s0 = starts; e0 = err_seen;
    send_byte(8'h33);
    repeat (10) @(negedge clk);
    check(err_seen == e0 + 1 && starts == s0, "R9 stray byte dropped", err_seen, e0 + 1);
    drdy_pulse();
    queue_frame();
    drdy_pulse();
    wait_quiet();
    check(starts == s0 + 27 && exp_rsp.size() == 0, "R9 streaming continues", starts, s0 + 27);

    // R8 stop streaming
    want(8'h11);
    send_byte(8'h11);
    wait_quiet();
    model_stream = 1'b0;
    s0 = starts;
    for (int k = 0; k < 4; k++) drdy_pulse();
    wait_quiet();
    check(starts == s0, "R8 no frames after stop", starts, s0);
    do_rreg(9, 2);
    wait_quiet();
    check(exp_rsp.size() == 0, "R8 idle commands after stop", exp_rsp.size(), 0);

    // R5 stall covered every select window
    check(stall_gap == 0, "R5 stall high while select low", stall_gap, 0);
    check(exp_mosi.size() == 0, "R2 no missing SPI bytes", exp_mosi.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule